// File: doc/BRIEF.md
# Exception Vector Remap Decoder

This block sits between a small processor and its memories and decides where instruction and data fetches in the exception-vector window go. The window is the first 64 bytes of the address space, starting at address zero. A 2-bit mapping mode, held in an 8-bit register on a simple register bus, steers that window to one of four regions: boot ROM, on-chip flash, static RAM, or external memory bank 0. The block outputs a region select and the address translated into the chosen region.

Fetches outside the window pass through with their address unchanged. Their region select comes from decoding the fixed base of each region. So every region can still be reached at its own base address while it is also mapped into the window. After reset the mode is zero, so the vectors come from boot ROM. A build parameter marks a flashless variant. In that variant mode 01 is treated as reserved and falls back to boot ROM.

The register bus uses a two-state handshake. The state machine has two states. ST_IDLE waits for a select and moves to ST_ACK on it (transition "accept"). ST_ACK drives the acknowledge and read data for one cycle and always returns to ST_IDLE (transition "release"). A write lands on the accept edge. Address decode is combinational from the stored mode, so any fetch presented after the acknowledge already sees the new mapping.

Top module: `vremap_top`

## Requirements
- R1: After reset the register reads 0x00, and a fetch at address 0x0 gets region code 1 (boot ROM) at address BOOT_BASE.
- R2: A fetch address below 64 is in the window. With mode 00 the region code is 1 (boot ROM) and the output address is BOOT_BASE plus address bits [5:0].
- R3: In the window with mode 01 and FLASHLESS=0, the region code is 2 (flash) and the output address is FLASH_BASE plus the offset. FLASH_BASE is 0 by default, so the fetch is not remapped.
- R4: In the window with mode 10, the region code is 3 (static RAM) and the output address is SRAM_BASE plus the offset.
- R5: In the window with mode 11, the region code is 4 (external bank 0) and the output address is EXT_BASE plus the offset.
- R6: A fetch at address 64 or above leaves the output address equal to the input address. Its region code comes from the native region decode, and an address in no region gets code 0.
- R7: An address inside a region's native range (base, size 2^RGN_AW bytes) selects that region's code whatever the mode is.
- R8: On a register access, the select sampled in ST_IDLE moves the block to ST_ACK. The acknowledge is high for exactly the following cycle. A write stores wdata bits [1:0] on the accept edge. Read data during the acknowledge is {6'b0, mode}, so bits [7:2] always read zero even after ones are written to them.
- R9: With FLASHLESS=1, mode 01 in the window gives region code 1 (boot ROM) at BOOT_BASE plus the offset.
- R10: A fetch presented after a write's acknowledge reflects the new mode. With no write accepted, the region output for a steady address does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Register access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_wdata | input | 8 | Write data; bits [1:0] are the mode |
| cfg_rdata | output | 8 | Read data, valid while cfg_ack is high |
| cfg_ack | output | 1 | One-cycle access acknowledge |
| fetch_addr | input | AW | Processor fetch address |
| fetch_rgn | output | 3 | Region code: 0 none, 1 boot ROM, 2 flash, 3 SRAM, 4 external |
| fetch_addr_out | output | AW | Address translated into the selected region |

## Verification
The hardest case to reach from the ports is aliasing. It needs the same physical region to be hit through the window and through its native range while the mode points elsewhere. The stimulus sets each mode in turn and then fetches both window offsets and native addresses of every region. The flashless fallback needs a second instance built with FLASHLESS=1. That instance shares the register bus, so one write of mode 01 drives both instances, and their differing results are compared in the same scoreboard.

// File: rtl/vremap_pkg.sv
package vremap_pkg;

    typedef enum logic [2:0] {
        RGN_NONE  = 3'd0,
        RGN_BOOT  = 3'd1,
        RGN_FLASH = 3'd2,
        RGN_SRAM  = 3'd3,
        RGN_EXT   = 3'd4
    } rgn_e;

    typedef enum logic [1:0] {
        MAP_BOOT  = 2'b00,
        MAP_FLASH = 2'b01,
        MAP_SRAM  = 2'b10,
        MAP_EXT   = 2'b11
    } map_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } bus_st_e;

endpackage

// File: rtl/vremap_regs.sv
module vremap_regs
    import vremap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ack,
    output map_e          mode
);

    localparam int RSV_W = DW - 2;

    bus_st_e state, state_nx;

    // state register and mode capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mode  <= MAP_BOOT;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && sel && wr)
                mode <= map_e'(wdata[1:0]);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (sel) state_nx = ST_ACK;   // accept
            ST_ACK:  state_nx = ST_IDLE;           // release
        endcase
    end

    // outputs
    always_comb begin
        ack   = 1'b0;
        rdata = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ACK: begin
                ack   = 1'b1;
                rdata = {{RSV_W{1'b0}}, mode};
            end
        endcase
    end

endmodule

// File: rtl/vremap_xlate.sv
module vremap_xlate
    import vremap_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          WIN_BYTES  = 64,
    parameter int          RGN_AW     = 16,
    parameter bit          FLASHLESS  = 1'b0,
    parameter logic [31:0] BOOT_BASE  = 32'h1000_0000,
    parameter logic [31:0] FLASH_BASE = 32'h0000_0000,
    parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
    parameter logic [31:0] EXT_BASE   = 32'h8000_0000
) (
    input  map_e          mode,
    input  logic [AW-1:0] addr,
    output logic [2:0]    rgn,
    output logic [AW-1:0] addr_out
);

    localparam int WIN_AW = $clog2(WIN_BYTES);
    localparam int NRGN   = 4;
    localparam logic [AW-1:0] BASES [NRGN] = '{
        BOOT_BASE[AW-1:0], FLASH_BASE[AW-1:0],
        SRAM_BASE[AW-1:0], EXT_BASE[AW-1:0]
    };

    logic [NRGN-1:0] nat_hit;
    logic            in_win;
    logic [AW-1:0]   off;

    for (genvar i = 0; i < NRGN; i++) begin : g_nat
        assign nat_hit[i] = (addr[AW-1:RGN_AW] == BASES[i][AW-1:RGN_AW]);
    end

    assign in_win = (addr[AW-1:WIN_AW] == '0);
    assign off    = {{(AW-WIN_AW){1'b0}}, addr[WIN_AW-1:0]};

    always_comb begin
        rgn      = RGN_NONE;
        addr_out = addr;
        if (in_win) begin
            unique case (mode)
                MAP_BOOT: begin
                    rgn = RGN_BOOT;  addr_out = BASES[0] + off;
                end
                MAP_FLASH: begin
                    if (FLASHLESS) begin
                        rgn = RGN_BOOT;  addr_out = BASES[0] + off;
                    end else begin
                        rgn = RGN_FLASH; addr_out = BASES[1] + off;
                    end
                end
                MAP_SRAM: begin
                    rgn = RGN_SRAM;  addr_out = BASES[2] + off;
                end
                MAP_EXT: begin
                    rgn = RGN_EXT;   addr_out = BASES[3] + off;
                end
            endcase
        end else if (nat_hit[0]) rgn = RGN_BOOT;
        else if (nat_hit[1])     rgn = RGN_FLASH;
        else if (nat_hit[2])     rgn = RGN_SRAM;
        else if (nat_hit[3])     rgn = RGN_EXT;
    end

endmodule

// File: rtl/vremap_top.sv
module vremap_top
    import vremap_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          WIN_BYTES  = 64,
    parameter int          RGN_AW     = 16,
    parameter bit          FLASHLESS  = 1'b0,
    parameter logic [31:0] BOOT_BASE  = 32'h1000_0000,
    parameter logic [31:0] FLASH_BASE = 32'h0000_0000,
    parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
    parameter logic [31:0] EXT_BASE   = 32'h8000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sel,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    output logic          cfg_ack,
    input  logic [AW-1:0] fetch_addr,
    output logic [2:0]    fetch_rgn,
    output logic [AW-1:0] fetch_addr_out
);

    map_e mode;

    vremap_regs #(.DW(8)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cfg_sel),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .ack   (cfg_ack),
        .mode  (mode)
    );

    vremap_xlate #(
        .AW(AW), .WIN_BYTES(WIN_BYTES), .RGN_AW(RGN_AW), .FLASHLESS(FLASHLESS),
        .BOOT_BASE(BOOT_BASE), .FLASH_BASE(FLASH_BASE),
        .SRAM_BASE(SRAM_BASE), .EXT_BASE(EXT_BASE)
    ) u_xlate (
        .mode     (mode),
        .addr     (fetch_addr),
        .rgn      (fetch_rgn),
        .addr_out (fetch_addr_out)
    );

endmodule

// File: rtl/vremap_chk.sv
module vremap_chk #(
    parameter int AW        = 32,
    parameter int WIN_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_sel,
    input logic          cfg_wr,
    input logic          cfg_ack,
    input logic [7:0]    cfg_rdata,
    input logic [AW-1:0] fetch_addr,
    input logic [2:0]    fetch_rgn,
    input logic [AW-1:0] fetch_addr_out
);

    localparam int WIN_AW = $clog2(WIN_BYTES);

    logic in_win;
    assign in_win = (fetch_addr < AW'(WIN_BYTES));

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);                                       // R8
    AST_ACK_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel && !cfg_ack) |=> cfg_ack);                          // R8
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |-> (cfg_rdata[7:2] == 6'd0));                       // R8
    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (fetch_addr_out == fetch_addr));                 // R6
    AST_WIN_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (fetch_addr_out[WIN_AW-1:0] == fetch_addr[WIN_AW-1:0]
                    && fetch_rgn != 3'd0));                          // R2
    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cfg_sel && cfg_wr && !cfg_ack) && in_win && $stable(fetch_addr))
        |=> ($stable(fetch_addr) -> $stable(fetch_rgn)));            // R10

endmodule

bind vremap_top vremap_chk #(.AW(AW), .WIN_BYTES(WIN_BYTES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_sel        (cfg_sel),
    .cfg_wr         (cfg_wr),
    .cfg_ack        (cfg_ack),
    .cfg_rdata      (cfg_rdata),
    .fetch_addr     (fetch_addr),
    .fetch_rgn      (fetch_rgn),
    .fetch_addr_out (fetch_addr_out)
);

// File: tb/vremap_top_tb.sv
module vremap_top_tb;

    localparam int          AW    = 32;
    localparam logic [31:0] BOOTB = 32'h1000_0000;
    localparam logic [31:0] FLSHB = 32'h0000_0000;
    localparam logic [31:0] SRAMB = 32'h2000_0000;
    localparam logic [31:0] EXTB  = 32'h8000_0000;

    typedef struct {
        bit          nf;
        logic [31:0] addr;
        logic [2:0]  rgn;
        logic [31:0] aout;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata, nf_rdata;
    logic        cfg_ack, nf_ack;
    logic [31:0] fetch_addr = '0;
    logic [2:0]  fetch_rgn, nf_rgn;
    logic [31:0] fetch_addr_out, nf_addr_out;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    vremap_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack),
        .fetch_addr(fetch_addr), .fetch_rgn(fetch_rgn),
        .fetch_addr_out(fetch_addr_out)
    );

    vremap_top #(.FLASHLESS(1'b1)) u_dut_nf (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(nf_rdata), .cfg_ack(nf_ack),
        .fetch_addr(fetch_addr), .fetch_rgn(nf_rgn),
        .fetch_addr_out(nf_addr_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle and compares it
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [2:0]  r;
            logic [31:0] a;
            it = sb.pop_front();
            r  = it.nf ? nf_rgn : fetch_rgn;
            a  = it.nf ? nf_addr_out : fetch_addr_out;
            check(r == it.rgn, {it.tag, " region"}, {29'd0, r}, {29'd0, it.rgn});
            check(a == it.aout, {it.tag, " addr"}, a, it.aout);
        end
    end

    // driver: presents an address and pushes the expected result
    task automatic fetch(input logic [31:0] a, input logic [2:0] r,
                         input logic [31:0] ao, input string tag, input bit nf = 0);
        item_t it;
        @(posedge clk);
        fetch_addr <= a;
        it.nf = nf; it.addr = a; it.rgn = r; it.aout = ao; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic reg_access(input bit wr, input logic [7:0] wd,
                              input logic [7:0] exp_rd, input string tag);
        @(posedge clk);
        cfg_sel <= 1'b1; cfg_wr <= wr; cfg_wdata <= wd;
        @(posedge clk);
        cfg_sel <= 1'b0; cfg_wr <= 1'b0;
        @(negedge clk);
        check(cfg_ack == 1'b1, {tag, " ack high"}, {31'd0, cfg_ack}, 32'd1);
        check(cfg_rdata == exp_rd, {tag, " rdata"}, {24'd0, cfg_rdata}, {24'd0, exp_rd});
        @(negedge clk);
        check(cfg_ack == 1'b0, {tag, " ack one cycle"}, {31'd0, cfg_ack}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_ack == 1'b0, "R1 ack idle", {31'd0, cfg_ack}, 32'd0);
        reg_access(1'b0, 8'h00, 8'h00, "R1 reset readback");
        fetch(32'h0, 3'd1, BOOTB, "R1 reset vector");
        // R2 boot mode in window
        fetch(32'h8, 3'd1, BOOTB + 32'h8, "R2 boot swi");
        fetch(32'h3C, 3'd1, BOOTB + 32'h3C, "R2 boot last word");
        // R6 pass-through and window edge
        fetch(32'h40, 3'd2, 32'h40, "R6 first addr past window");
        fetch(32'h5000_0000, 3'd0, 32'h5000_0000, "R6 unmapped");
        // R8 reserved ones written, only mode kept
        reg_access(1'b1, 8'hFD, 8'h01, "R8 write rsv ones");
        reg_access(1'b0, 8'h00, 8'h01, "R8 readback");
        // R3 flash mode, R9 flashless fallback, R10 takes effect
        fetch(32'h18, 3'd2, FLSHB + 32'h18, "R3 flash window");
        fetch(32'h18, 3'd1, BOOTB + 32'h18, "R9 flashless fallback", 1'b1);
        fetch(32'h0, 3'd1, BOOTB, "R9 flashless reset vec", 1'b1);
        // R4 SRAM mode
        reg_access(1'b1, 8'h02, 8'h02, "R4 write sram");
        fetch(32'h1C, 3'd3, SRAMB + 32'h1C, "R4 sram window R10");
        fetch(32'h1C, 3'd3, SRAMB + 32'h1C, "R4 sram nf", 1'b1);
        // R7 aliases while SRAM mapped
        fetch(SRAMB + 32'h1C, 3'd3, SRAMB + 32'h1C, "R7 sram native");
        fetch(BOOTB + 32'h4, 3'd1, BOOTB + 32'h4, "R7 boot native");
        fetch(32'h100, 3'd2, 32'h100, "R7 flash native");
        // R5 external mode
        reg_access(1'b1, 8'h03, 8'h03, "R5 write ext");
        fetch(32'h3F, 3'd4, EXTB + 32'h3F, "R5 ext window");
        fetch(EXTB + 32'h80, 3'd4, EXTB + 32'h80, "R7 ext native");
        fetch(32'h40, 3'd2, 32'h40, "R6 past window ext mode");
        // back to boot
        reg_access(1'b1, 8'h00, 8'h00, "R2 write boot");
        fetch(32'h14, 3'd1, BOOTB + 32'h14, "R2 boot again");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule